// File: doc/BRIEF.md
# Byte-Mapped Interval Timer with Interrupt Flags

This block is a byte-wide, register-mapped peripheral core. It holds a free-running
16-bit interval timer that reloads itself from a latch, a 16-bit down counter, a
flag register, an enable register, an auxiliary mode register and a handful of plain
storage bytes used by neighbouring port and serial logic. A single level interrupt
output is raised when an enabled timer or serial flag is pending.

Software reaches the core through a synchronous port: a read strobe returns data in
the same cycle, and the side effects of that read take hold at the next clock edge.
Both counters advance only on cycles where the `tick` enable is high. The serial
shifter itself lives elsewhere; it reports a completed byte on `shift_done` and this
core keeps only the matching flag. The register index is taken from address bits
[12:9].

Top module: `ptmr_core`

## Requirements
- R1: After reset, every register reads 0x00 except the interval counter, the interval latch and the down counter (all bytes 0xFF) and the enable register, which reads 0x80.
- R2: The register index is addr[12:9]; lower address bits are ignored. Indexes 0, 1, 2, 3, 10, 11, 12 and 15 are plain bytes that read back what was last written.
- R3: On each tick the interval counter (indexes 4 low, 5 high) decrements; from 0 it goes to 0xFFFF and from 0xFFFF it reloads the latch, so one period is latch+2 ticks. Without a tick it holds.
- R4: Writing index 5 sets the latch high byte, loads the counter from the full latch and clears flag bit 6. Writing index 4 or 6 changes only the latch low byte; writing index 7 sets the latch high byte and clears flag bit 6 without a reload. Indexes 6/7 read the latch.
- R5: Flag bit 6 is set when the interval counter reaches 0 on a tick, only while index 11 bits [7:6] equal 01.
- R6: A read of index 4 clears flag bit 6 at the next edge; a read of index 5 does not.
- R7: A `shift_done` pulse sets flag bit 2; a read of index 10 clears it.
- R8: Writing index 13 clears each flag whose data bit is 1. Reading index 13 returns the flags with bit 7 set when any flag is both pending and enabled.
- R9: A write to index 14 with bit 7 = 1 sets the enable bits given in [6:0]; with bit 7 = 0 it clears the enable bits given as 1. Index 14 reads the enables with bit 7 forced to 1.
- R10: `irq` is high exactly when flag and enable are both set in bit 6 or in bit 2; other enable bits have no effect on it.
- R11: The down counter (index 8 low, 9 high) decrements per tick and wraps at 16 bits. Writing index 8 stores a low byte only; writing index 9 loads the counter with {written byte, stored low byte}.
- R12: When a flag is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Counter advance enable |
| shift_done | input | 1 | Serial byte completed, sets flag bit 2 |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 13 | Byte address; index in bits [12:9] |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid in the strobe cycle |
| irq | output | 1 | Level interrupt |

## Verification
The assertions take for granted that `rd_en` and `wr_en` are never high together and that `tick` may coincide with any access, so a counter load and a tick can meet in one cycle with the load taking priority. The stimulus issues at most one access per cycle, drives every input half a cycle away from the sampling edge, and holds `tick` low during reads whose expected counter value it has computed, so each read checks a settled count. Simultaneous set and clear of a flag is produced on purpose only through `shift_done` together with a read of index 10.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int DW    = 8;
    localparam int CW    = 16;
    localparam int IDX_W = 4;
    localparam int FW    = 7;

    typedef enum logic [IDX_W-1:0] {
        IX_PB   = 4'd0,
        IX_PA   = 4'd1,
        IX_DB   = 4'd2,
        IX_DA   = 4'd3,
        IX_T1CL = 4'd4,
        IX_T1CH = 4'd5,
        IX_T1LL = 4'd6,
        IX_T1LH = 4'd7,
        IX_T2L  = 4'd8,
        IX_T2H  = 4'd9,
        IX_SHF  = 4'd10,
        IX_AUX  = 4'd11,
        IX_PCTL = 4'd12,
        IX_FLG  = 4'd13,
        IX_ENA  = 4'd14,
        IX_PANH = 4'd15
    } reg_idx_e;

    localparam int FB_SHIFT = 2;
    localparam int FB_T2    = 5;
    localparam int FB_T1    = 6;

    localparam logic [FW-1:0] IRQ_SRC_MASK = (FW'(1) << FB_T1) | (FW'(1) << FB_SHIFT);

    localparam int NPLAIN = 8;
    localparam int SLOT_W = $clog2(NPLAIN);

    typedef struct packed {
        logic     rd;
        logic     wr;
        reg_idx_e idx;
        logic [DW-1:0] data;
    } bus_req_t;

    typedef struct packed {
        logic valid;
        logic [SLOT_W-1:0] slot;
    } slot_t;

    function automatic slot_t plain_slot(input reg_idx_e idx);
        slot_t s;
        s.valid = 1'b1;
        case (idx)
            IX_PB:   s.slot = 3'd0;
            IX_PA:   s.slot = 3'd1;
            IX_DB:   s.slot = 3'd2;
            IX_DA:   s.slot = 3'd3;
            IX_SHF:  s.slot = 3'd4;
            IX_AUX:  s.slot = 3'd5;
            IX_PCTL: s.slot = 3'd6;
            IX_PANH: s.slot = 3'd7;
            default: begin
                s.valid = 1'b0;
                s.slot  = 3'd0;
            end
        endcase
        return s;
    endfunction

    function automatic logic t1_continuous(input logic [DW-1:0] aux);
        return aux[7:6] == 2'b01;
    endfunction

endpackage

// File: rtl/ptmr_interval.sv
module ptmr_interval #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          lat_lo_we,
    input  logic          lat_hi_we,
    input  logic          load,
    input  logic [CW/2-1:0] wbyte,
    output logic [CW-1:0] count,
    output logic [CW-1:0] latch,
    output logic          zero_hit
);
    localparam int HW = CW / 2;

    logic [CW-1:0] latch_nx;
    logic [CW-1:0] count_nx;

    always_comb begin
        latch_nx = latch;
        if (lat_lo_we) latch_nx[HW-1:0]  = wbyte;
        if (lat_hi_we) latch_nx[CW-1:HW] = wbyte;
    end

    always_comb begin
        count_nx = count;
        if (load) begin
            count_nx = latch_nx;
        end else if (tick) begin
            if (count == '1) count_nx = latch;
            else             count_nx = count - 1'b1;
        end
    end

    assign zero_hit = tick && !load && (count_nx == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            latch <= '1;
            count <= '1;
        end else begin
            latch <= latch_nx;
            count <= count_nx;
        end
    end

    p_reload_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && count == '1) |=> count == $past(latch));
    p_zero_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && !load && count == '0) |=> count == '1);
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(count));
    p_load_r4: assert property (@(posedge clk) disable iff (rst)
        (load && lat_hi_we) |=> count[CW-1:HW] == $past(wbyte));

endmodule

// File: rtl/ptmr_oneshot.sv
module ptmr_oneshot #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          lo_we,
    input  logic          hi_we,
    input  logic [CW/2-1:0] wbyte,
    output logic [CW-1:0] count
);
    localparam int HW = CW / 2;

    logic [HW-1:0] lo_hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_hold <= '0;
            count   <= '1;
        end else begin
            if (lo_we) lo_hold <= wbyte;
            if (hi_we)     count <= {wbyte, lo_hold};
            else if (tick) count <= count - 1'b1;
        end
    end

    p_t2_dec_r11: assert property (@(posedge clk) disable iff (rst)
        (tick && !hi_we) |=> count == $past(count) - 1'b1);
    p_t2_lo_only_r11: assert property (@(posedge clk) disable iff (rst)
        (!tick && !hi_we) |=> $stable(count));

endmodule

// File: rtl/ptmr_irq.sv
module ptmr_irq #(
    parameter int FW = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [FW-1:0] set_vec,
    input  logic [FW-1:0] clr_vec,
    input  logic          ena_we,
    input  logic [FW:0]   ena_wdata,
    input  logic [FW-1:0] src_mask,
    output logic [FW-1:0] flags,
    output logic [FW-1:0] enables,
    output logic          any_pend,
    output logic          irq
);
    logic [FW-1:0] flags_nx;
    logic [FW-1:0] ena_nx;

    always_comb begin
        flags_nx = (flags & ~clr_vec) | set_vec;
        ena_nx   = enables;
        if (ena_we) begin
            if (ena_wdata[FW]) ena_nx = enables | ena_wdata[FW-1:0];
            else               ena_nx = enables & ~ena_wdata[FW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags   <= '0;
            enables <= '0;
        end else begin
            flags   <= flags_nx;
            enables <= ena_nx;
        end
    end

    assign any_pend = |(flags & enables);
    assign irq      = |(flags & enables & src_mask);

    p_set_wins_r12: assert property (@(posedge clk) disable iff (rst)
        (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec)));
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (clr_vec != '0 && set_vec == '0) |=> ((flags & $past(clr_vec)) == '0));
    p_ena_set_r9: assert property (@(posedge clk) disable iff (rst)
        (ena_we && ena_wdata[FW]) |=> ((enables & $past(ena_wdata[FW-1:0])) == $past(ena_wdata[FW-1:0])));
    p_ena_clr_r9: assert property (@(posedge clk) disable iff (rst)
        (ena_we && !ena_wdata[FW]) |=> ((enables & $past(ena_wdata[FW-1:0])) == '0));

endmodule

// File: rtl/ptmr_bytebank.sv
module ptmr_bytebank #(
    parameter int N  = 8,
    parameter int DW = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N-1:0]          we_vec,
    input  logic [DW-1:0]         wdata,
    output logic [N-1:0][DW-1:0]  q
);
    for (genvar g = 0; g < N; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)            q[g] <= '0;
            else if (we_vec[g]) q[g] <= wdata;
        end
    end

    p_onehot_we_r2: assert property (@(posedge clk) disable iff (rst) $onehot0(we_vec));

endmodule

// File: rtl/ptmr_core.sv
module ptmr_core
    import ptmr_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int IDX_LSB = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              shift_done,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output logic              irq
);
    localparam int HW = CW / 2;

    bus_req_t req;
    slot_t    sl;

    assign req.rd   = rd_en;
    assign req.wr   = wr_en;
    assign req.idx  = reg_idx_e'(addr[IDX_LSB+IDX_W-1:IDX_LSB]);
    assign req.data = wdata;
    assign sl       = plain_slot(req.idx);

    // plain storage bytes
    logic [NPLAIN-1:0]         plain_we;
    logic [NPLAIN-1:0][DW-1:0] plain_q;

    always_comb begin
        plain_we = '0;
        if (req.wr && sl.valid) plain_we[sl.slot] = 1'b1;
    end

    ptmr_bytebank #(.N(NPLAIN), .DW(DW)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .we_vec (plain_we),
        .wdata  (req.data),
        .q      (plain_q)
    );

    logic [DW-1:0] aux_q;
    assign aux_q = plain_q[5];

    // interval timer
    logic          t1_lo_we, t1_hi_we, t1_load, t1_hit;
    logic [CW-1:0] t1_count, t1_latch;

    assign t1_lo_we = req.wr && (req.idx == IX_T1CL || req.idx == IX_T1LL);
    assign t1_hi_we = req.wr && (req.idx == IX_T1CH || req.idx == IX_T1LH);
    assign t1_load  = req.wr && (req.idx == IX_T1CH);

    ptmr_interval #(.CW(CW)) u_t1 (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .lat_lo_we (t1_lo_we),
        .lat_hi_we (t1_hi_we),
        .load      (t1_load),
        .wbyte     (req.data),
        .count     (t1_count),
        .latch     (t1_latch),
        .zero_hit  (t1_hit)
    );

    // down counter
    logic [CW-1:0] t2_count;

    ptmr_oneshot #(.CW(CW)) u_t2 (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .lo_we (req.wr && req.idx == IX_T2L),
        .hi_we (req.wr && req.idx == IX_T2H),
        .wbyte (req.data),
        .count (t2_count)
    );

    // flags and enables
    logic [FW-1:0] set_vec, clr_vec, flags, enables;
    logic          any_pend;

    always_comb begin
        set_vec = '0;
        set_vec[FB_T1]    = t1_hit && t1_continuous(aux_q);
        set_vec[FB_SHIFT] = shift_done;
    end

    always_comb begin
        clr_vec = '0;
        if (req.rd) begin
            if (req.idx == IX_T1CL) clr_vec[FB_T1]    = 1'b1;
            if (req.idx == IX_SHF)  clr_vec[FB_SHIFT] = 1'b1;
            if (req.idx == IX_T2L)  clr_vec[FB_T2]    = 1'b1;
        end
        if (req.wr) begin
            if (req.idx == IX_T1CH || req.idx == IX_T1LH) clr_vec[FB_T1] = 1'b1;
            if (req.idx == IX_FLG) clr_vec = clr_vec | req.data[FW-1:0];
        end
    end

    ptmr_irq #(.FW(FW)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .set_vec   (set_vec),
        .clr_vec   (clr_vec),
        .ena_we    (req.wr && req.idx == IX_ENA),
        .ena_wdata (req.data),
        .src_mask  (IRQ_SRC_MASK),
        .flags     (flags),
        .enables   (enables),
        .any_pend  (any_pend),
        .irq       (irq)
    );

    // read mux
    always_comb begin
        rdata = '0;
        if (req.rd) begin
            case (req.idx)
                IX_T1CL: rdata = t1_count[HW-1:0];
                IX_T1CH: rdata = t1_count[CW-1:HW];
                IX_T1LL: rdata = t1_latch[HW-1:0];
                IX_T1LH: rdata = t1_latch[CW-1:HW];
                IX_T2L:  rdata = t2_count[HW-1:0];
                IX_T2H:  rdata = t2_count[CW-1:HW];
                IX_FLG:  rdata = {any_pend, flags};
                IX_ENA:  rdata = {1'b1, enables};
                default: rdata = plain_q[sl.slot];
            endcase
        end
    end

    p_excl_r2: assert property (@(posedge clk) disable iff (rst) !(rd_en && wr_en));
    p_mode_gate_r5: assert property (@(posedge clk) disable iff (rst)
        (!t1_continuous(aux_q) && !shift_done) |=> !$rose(flags[FB_T1]));
    p_rdclr_r6: assert property (@(posedge clk) disable iff (rst)
        (rd_en && req.idx == IX_T1CL && !set_vec[FB_T1]) |=> !flags[FB_T1]);
    p_shift_r7: assert property (@(posedge clk) disable iff (rst)
        shift_done |=> flags[FB_SHIFT]);

endmodule

// File: tb/ptmr_core_tb.sv
module ptmr_core_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        shift_done = 1'b0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [12:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    ptmr_core dut_i (
        .clk(clk), .rst(rst), .tick(tick), .shift_done(shift_done),
        .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq(irq)
    );

    typedef struct {
        int       idx;
        logic [7:0] exp;
        string    req;
    } item_t;

    item_t sb_q[$];

    // monitor: compares read data against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rd_en) begin
                if (sb_q.size() == 0) begin
                    n_run++; n_fail++;
                    $display("FAIL scoreboard empty on read, actual %02h expected none", rdata);
                end else begin
                    item_t it;
                    it = sb_q.pop_front();
                    n_run++;
                    if (rdata !== it.exp) begin
                        n_fail++;
                        $display("FAIL %s index %0d: actual %02h expected %02h",
                                 it.req, it.idx, rdata, it.exp);
                    end
                end
            end
        end
    end

    task automatic op(bit rd, bit wr, int idx, logic [7:0] d, bit tk, bit sh);
        @(negedge clk);
        rd_en      = rd;
        wr_en      = wr;
        addr       = {idx[3:0], 9'h0A5};
        wdata      = d;
        tick       = tk;
        shift_done = sh;
    endtask

    task automatic rd_chk(int idx, logic [7:0] exp, string req);
        item_t it;
        it.idx = idx; it.exp = exp; it.req = req;
        sb_q.push_back(it);
        op(1, 0, idx, 8'h00, 0, 0);
    endtask

    task automatic wr_reg(int idx, logic [7:0] d);
        op(0, 1, idx, d, 0, 0);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) op(0, 0, 0, 8'h00, 1, 0);
    endtask

    task automatic irq_chk(logic exp, string req);
        op(0, 0, 0, 8'h00, 0, 0);
        #2;
        n_run++;
        if (irq !== exp) begin
            n_fail++;
            $display("FAIL %s irq: actual %0b expected %0b", req, irq, exp);
        end
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired, actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_chk(4, 8'hFF, "R1"); rd_chk(5, 8'hFF, "R1");
        rd_chk(6, 8'hFF, "R1"); rd_chk(7, 8'hFF, "R1");
        rd_chk(8, 8'hFF, "R1"); rd_chk(9, 8'hFF, "R1");
        rd_chk(13, 8'h00, "R1"); rd_chk(14, 8'h80, "R1");
        rd_chk(11, 8'h00, "R1"); rd_chk(0, 8'h00, "R1");
        irq_chk(1'b0, "R1");

        // R2 plain bytes, lower address bits ignored
        wr_reg(0, 8'h5A); wr_reg(1, 8'hA5); wr_reg(2, 8'hC3); wr_reg(3, 8'h3C);
        wr_reg(10, 8'h96); wr_reg(11, 8'h3C); wr_reg(12, 8'h81); wr_reg(15, 8'h7E);
        rd_chk(0, 8'h5A, "R2"); rd_chk(1, 8'hA5, "R2"); rd_chk(2, 8'hC3, "R2");
        rd_chk(3, 8'h3C, "R2"); rd_chk(10, 8'h96, "R2"); rd_chk(11, 8'h3C, "R2");
        rd_chk(12, 8'h81, "R2"); rd_chk(15, 8'h7E, "R2");
        wr_reg(11, 8'h00);

        // R4 latch writes without reload
        wr_reg(6, 8'h05); wr_reg(7, 8'h00);
        rd_chk(4, 8'hFF, "R4"); rd_chk(6, 8'h05, "R4"); rd_chk(7, 8'h00, "R4");
        wr_reg(4, 8'h03);
        rd_chk(6, 8'h03, "R4"); rd_chk(5, 8'hFF, "R4");
        wr_reg(5, 8'h00);
        rd_chk(4, 8'h03, "R4"); rd_chk(5, 8'h00, "R4");

        // R3 countdown, wrap and reload (period latch+2)
        ticks(1); rd_chk(4, 8'h02, "R3");
        ticks(1); rd_chk(4, 8'h01, "R3");
        ticks(1); rd_chk(4, 8'h00, "R3");
        ticks(1); rd_chk(4, 8'hFF, "R3"); rd_chk(5, 8'hFF, "R3");
        ticks(1); rd_chk(4, 8'h03, "R3"); rd_chk(5, 8'h00, "R3");
        op(0, 0, 0, 8'h00, 0, 0); op(0, 0, 0, 8'h00, 0, 0);
        rd_chk(4, 8'h03, "R3");

        // R5 flag only in continuous mode
        rd_chk(13, 8'h00, "R5");
        wr_reg(11, 8'h40); wr_reg(5, 8'h00);
        ticks(3);
        rd_chk(13, 8'h40, "R5");

        // R9 / R10 enable convention and irq sources
        wr_reg(14, 8'hC0);
        rd_chk(14, 8'hC0, "R9"); irq_chk(1'b1, "R10"); rd_chk(13, 8'hC0, "R8");
        wr_reg(14, 8'h40);
        rd_chk(14, 8'h80, "R9"); irq_chk(1'b0, "R10");
        wr_reg(14, 8'hA0);
        rd_chk(14, 8'hA0, "R9"); irq_chk(1'b0, "R10"); rd_chk(13, 8'h40, "R8");
        wr_reg(14, 8'hC0);
        irq_chk(1'b1, "R10");

        // R6 read side effect
        rd_chk(5, 8'h00, "R6"); rd_chk(13, 8'hC0, "R6");
        rd_chk(4, 8'h00, "R6"); rd_chk(13, 8'h00, "R6");
        irq_chk(1'b0, "R6");

        // R8 flag clear by write
        ticks(5);
        rd_chk(13, 8'hC0, "R8");
        wr_reg(13, 8'h04); rd_chk(13, 8'hC0, "R8");
        wr_reg(13, 8'h40); rd_chk(13, 8'h00, "R8");

        // R7 shift flag
        op(0, 0, 0, 8'h00, 0, 1);
        rd_chk(13, 8'h04, "R7"); irq_chk(1'b0, "R7");
        wr_reg(14, 8'h84);
        rd_chk(13, 8'h84, "R7"); irq_chk(1'b1, "R7");
        rd_chk(10, 8'h96, "R7");
        rd_chk(13, 8'h00, "R7"); irq_chk(1'b0, "R7");

        // R12 set beats a same-cycle clear
        begin
            item_t it;
            it.idx = 10; it.exp = 8'h96; it.req = "R12";
            sb_q.push_back(it);
            op(1, 0, 10, 8'h00, 0, 1);
        end
        rd_chk(13, 8'h84, "R12");
        wr_reg(13, 8'h04); rd_chk(13, 8'h00, "R12");

        // R4 index 7 clears flag without reload
        wr_reg(5, 8'h00); ticks(3);
        rd_chk(13, 8'hC0, "R4");
        wr_reg(7, 8'h00);
        rd_chk(13, 8'h00, "R4"); rd_chk(5, 8'h00, "R4"); rd_chk(4, 8'h00, "R4");
        ticks(1); rd_chk(5, 8'hFF, "R4");

        // R5 other modes give no flag
        wr_reg(11, 8'hC0); wr_reg(5, 8'h00); ticks(3);
        rd_chk(13, 8'h00, "R5"); irq_chk(1'b0, "R5");
        wr_reg(11, 8'h80); wr_reg(5, 8'h00); ticks(3);
        rd_chk(13, 8'h00, "R5");

        // R11 down counter
        wr_reg(8, 8'h34); wr_reg(9, 8'h12);
        rd_chk(8, 8'h34, "R11"); rd_chk(9, 8'h12, "R11");
        ticks(1); rd_chk(8, 8'h33, "R11");
        wr_reg(8, 8'h00); rd_chk(8, 8'h33, "R11");
        wr_reg(9, 8'h00); rd_chk(9, 8'h00, "R11"); rd_chk(8, 8'h00, "R11");
        ticks(1); rd_chk(8, 8'hFF, "R11"); rd_chk(9, 8'hFF, "R11");

        op(0, 0, 0, 8'h00, 0, 0);
        op(0, 0, 0, 8'h00, 0, 0);
        if (sb_q.size() != 0) begin
            n_run++; n_fail++;
            $display("FAIL scoreboard leftover, actual %0d expected 0", sb_q.size());
        end
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule